// File: doc/BRIEF.md
# Masked Alarm and Periodic Event Unit

This unit watches a running BCD clock and raises two kinds of event. The first is an alarm: a programmed word holds a target second, minute, hour and day of month, and each of the four fields carries its own compare enable. A field whose enable is clear is left out of the match. An alarm can therefore repeat every minute, every hour or every day, or fire once a month. The second is a periodic update event. It occurs on every seconds tick, or only on the tick that brings the seconds back to 00, and a single select pin chooses between the two.

The time counter sits outside the unit. On the cycle that `sec_tick` is high, the time inputs already show the new time, and the unit evaluates both events at that edge only. Each event sets a sticky status bit. Software clears a bit by writing 1 to it. A newly written alarm word goes through a staging register and becomes active `LOAD_LAT` cycles later, and `alarm_busy` is high while that load is in progress.

No data flows through this block, so it has no valid/ready interface. Every pin is a plain control or status signal, and none of them applies back-pressure.

Top module: `alarm_evt_unit`

## Requirements
- R1: After reset, `status` is 00, `irq` is 0 and `alarm_busy` is 0. The active alarm has all four compare enables at 0.
- R2: Alarm and time fields use the same bit positions: seconds in 6:0, minutes in 13:7, hours in 19:14, and day of month in 25:20. The day of month comes in on `mday_bcd` and sits at position 25:20 of the compared word. On a `sec_tick` cycle where every enabled field equals the time, `status[0]` is 1 from the next cycle on.
- R3: Alarm bits 26, 27, 28 and 29 enable the comparison of seconds, minutes, hours and day of month. A field whose enable is 0 has no effect on the match.
- R4: When all four compare enables of the active alarm are 0, `status[0]` never sets.
- R5: A match without `sec_tick` has no effect. `status[0]` can only rise in the cycle after a tick.
- R6: With `upd_per_sec` = 1, every `sec_tick` sets `status[1]` from the next cycle on.
- R7: With `upd_per_sec` = 0, `status[1]` sets only on a tick where the seconds field (`time_bcd[6:0]`) is 00.
- R8: Status bits are sticky. A cycle with `clr_wr` = 1 clears each bit whose `clr_mask` bit is 1, and leaves the other bit unchanged.
- R9: An event in the same cycle as a clear of its bit wins, and the bit stays 1.
- R10: `irq` = `status[0]` OR (`status[1]` AND `upd_int_en`).
- R11: An `alarm_wr` pulse makes `alarm_busy` 1 for exactly `LOAD_LAT` cycles, starting the cycle after the pulse. Until `alarm_busy` falls, matching uses the previously active alarm; after that it uses the new word. A write during busy restarts the load with the newer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse; the time inputs already hold the new time |
| time_bcd | input | 20 | Current BCD time: seconds 6:0, minutes 13:7, hours 19:14 |
| mday_bcd | input | 6 | Current BCD day of month |
| alarm_wdata | input | 30 | Alarm word: fields 25:0, compare enables 29:26 |
| alarm_wr | input | 1 | Write strobe for the alarm word |
| upd_int_en | input | 1 | Lets the update status drive the interrupt |
| upd_per_sec | input | 1 | 1: update event every second; 0: every minute |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 2 | Bits to clear (bit 0 alarm, bit 1 update) |
| status | output | 2 | Sticky status: bit 0 alarm, bit 1 update |
| irq | output | 1 | Interrupt request |
| alarm_busy | output | 1 | Alarm word load in progress |

## Verification
The bench targets these corner cases:
- **Fields ignored when disabled.** Only-seconds matching is tested against an unrelated minute and hour. A unit that still compared masked fields would miss this alarm.
- **All enables zero.** A word whose fields equal the time but whose enables are all zero must stay silent. A unit that treated "nothing enabled" as "everything matches" would fire on every tick.
- **Set and clear together.** An event that lands in the same cycle as its clear must leave the bit at 1. Giving the clear priority would drop that event.
- **Per-minute mode.** The update event must fire only at seconds 00. A per-minute mode that fired on other seconds would set `status[1]` too often.
- **Load window.** A tick that matches the new word while it is still loading must not fire. An alarm that went live at once would fire early.
- **Random sweep.** Randomised ticks, times, writes and clears are compared cycle by cycle against a bench model.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_W   = 30;
  localparam int CMP_W   = 26;
  localparam int FIELDS  = 4;
  localparam int EN_LSB  = CMP_W;
  localparam int TIME_W  = 20;
  localparam int DAY_W   = CMP_W - TIME_W;
  localparam int SEC_W   = 7;
  localparam int ST_N    = 2;
  localparam int ST_ALM  = 0;
  localparam int ST_UPD  = 1;

  // Bits of the compared word that belong to field idx (0 sec .. 3 day).
  function automatic logic [CMP_W-1:0] fld_mask(input int idx);
    case (idx)
      0:       fld_mask = 26'h000007F;
      1:       fld_mask = 26'h0003F80;
      2:       fld_mask = 26'h00FC000;
      default: fld_mask = 26'h3F00000;
    endcase
  endfunction
endpackage

// File: rtl/alm_loader.sv
module alm_loader
  import alm_pkg::*;
#(
  parameter int LOAD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ALM_W-1:0] wdata,
  output logic [ALM_W-1:0] active,
  output logic             busy
);
  localparam int CNT_W = $clog2(LOAD_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ALM_W-1:0] stage_q;
  logic [ALM_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= '0;
      act_q   <= '0;
    end else if (wr) begin
      stage_q <= wdata;
      cnt_q   <= CNT_W'(LOAD_LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) act_q <= stage_q;
    end
  end

  assign active = act_q;
  assign busy   = (cnt_q != '0);

  // R11
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> busy);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr) |=> $stable(active));
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic             tick,
  input  logic [ALM_W-1:0] alarm,
  input  logic [CMP_W-1:0] now,
  output logic             hit
);
  logic [FIELDS-1:0] fld_ok;
  logic [FIELDS-1:0] en;

  assign en = alarm[EN_LSB +: FIELDS];

  for (genvar g = 0; g < FIELDS; g++) begin : g_fld
    assign fld_ok[g] = !en[g] ||
      (((alarm[CMP_W-1:0] ^ now) & fld_mask(g)) == '0);
  end

  assign hit = tick && (en != '0) && (&fld_ok);
endmodule

// File: rtl/upd_gen.sv
module upd_gen
  import alm_pkg::*;
(
  input  logic             tick,
  input  logic             per_sec,
  input  logic [SEC_W-1:0] sec_bcd,
  output logic             evt
);
  assign evt = tick && (per_sec || (sec_bcd == '0));
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_r;
    always_ff @(posedge clk) begin
      if (!rst_n)                       q_r <= 1'b0;
      else if (set[i])                  q_r <= 1'b1;
      else if (clr_wr && clr_mask[i])   q_r <= 1'b0;
    end
    assign q[i] = q_r;

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !(clr_wr && clr_mask[i])) |=> q[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/alarm_evt_unit.sv
module alarm_evt_unit
  import alm_pkg::*;
#(
  parameter int LOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [TIME_W-1:0] time_bcd,
  input  logic [DAY_W-1:0]  mday_bcd,
  input  logic [ALM_W-1:0]  alarm_wdata,
  input  logic              alarm_wr,
  input  logic              upd_int_en,
  input  logic              upd_per_sec,
  input  logic              clr_wr,
  input  logic [ST_N-1:0]   clr_mask,
  output logic [ST_N-1:0]   status,
  output logic              irq,
  output logic              alarm_busy
);
  logic [ALM_W-1:0] act_alarm;
  logic             alm_hit;
  logic             upd_evt;
  logic [ST_N-1:0]  st_set;

  alm_loader #(.LOAD_LAT(LOAD_LAT)) u_load (
    .clk(clk), .rst_n(rst_n), .wr(alarm_wr), .wdata(alarm_wdata),
    .active(act_alarm), .busy(alarm_busy)
  );

  alm_match u_match (
    .tick(sec_tick), .alarm(act_alarm), .now({mday_bcd, time_bcd}),
    .hit(alm_hit)
  );

  upd_gen u_upd (
    .tick(sec_tick), .per_sec(upd_per_sec), .sec_bcd(time_bcd[SEC_W-1:0]),
    .evt(upd_evt)
  );

  always_comb begin
    st_set         = '0;
    st_set[ST_ALM] = alm_hit;
    st_set[ST_UPD] = upd_evt;
  end

  sticky_status #(.N(ST_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .q(status)
  );

  assign irq = status[ST_ALM] | (status[ST_UPD] & upd_int_en);

  // R5
  alm_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ALM]) |-> $past(sec_tick));
  // R4
  alm_need_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ALM]) |-> ($past(act_alarm[EN_LSB +: FIELDS]) != '0));
  // R6
  upd_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_UPD]) |-> $past(sec_tick));
endmodule

// File: tb/alarm_evt_unit_tb.sv
module alarm_evt_unit_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [19:0] time_bcd = '0;
  logic [5:0]  mday_bcd = '0;
  logic [29:0] alarm_wdata = '0;
  logic        alarm_wr = 1'b0;
  logic        upd_int_en = 1'b0;
  logic        upd_per_sec = 1'b0;
  logic        clr_wr = 1'b0;
  logic [1:0]  clr_mask = '0;
  logic [1:0]  status;
  logic        irq;
  logic        alarm_busy;

  int checks = 0;
  int errors = 0;

  logic [1:0]  m_st = '0;
  logic [29:0] m_act = '0;
  logic [29:0] m_stage = '0;
  int          m_cnt = 0;

  alarm_evt_unit #(.LOAD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_bcd(time_bcd),
    .mday_bcd(mday_bcd), .alarm_wdata(alarm_wdata), .alarm_wr(alarm_wr),
    .upd_int_en(upd_int_en), .upd_per_sec(upd_per_sec), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .status(status), .irq(irq), .alarm_busy(alarm_busy)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [29:0] mk_alarm(input logic [3:0] en, input int s,
                                           input int m, input int h, input int d);
    logic [7:0] bs, bm, bh, bd;
    bs = bcd(s); bm = bcd(m); bh = bcd(h); bd = bcd(d);
    return {en, bd[5:0], bh[5:0], bm[6:0], bs[6:0]};
  endfunction

  task automatic set_time(input int s, input int m, input int h, input int d);
    logic [7:0] bs, bm, bh, bd;
    bs = bcd(s); bm = bcd(m); bh = bcd(h); bd = bcd(d);
    time_bcd = {bh[5:0], bm[6:0], bs[6:0]};
    mday_bcd = bd[5:0];
  endtask

  // Match per R2/R3/R4, written from field positions.
  function automatic logic ref_match(input logic [29:0] a, input logic [19:0] t,
                                     input logic [5:0] d);
    logic ok;
    if (a[29:26] == 4'b0) return 1'b0;
    ok = 1'b1;
    if (a[26] && a[6:0]   != t[6:0])   ok = 1'b0;
    if (a[27] && a[13:7]  != t[13:7])  ok = 1'b0;
    if (a[28] && a[19:14] != t[19:14]) ok = 1'b0;
    if (a[29] && a[25:20] != d)        ok = 1'b0;
    return ok;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: model update at the edge, compare at the following negedge.
  task automatic step();
    logic [1:0] set;
    @(posedge clk);
    set[0] = sec_tick && ref_match(m_act, time_bcd, mday_bcd);
    set[1] = sec_tick && (upd_per_sec || time_bcd[6:0] == 7'd0);
    m_st = (m_st & ~(clr_wr ? clr_mask : 2'b00)) | set;
    if (alarm_wr) begin
      m_stage = alarm_wdata;
      m_cnt = LAT;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_act = m_stage;
    end
    @(negedge clk);
    chk("R2", 32'(status[0]), 32'(m_st[0]));
    chk("R6", 32'(status[1]), 32'(m_st[1]));
    chk("R10", 32'(irq), 32'(m_st[0] | (m_st[1] & upd_int_en)));
    chk("R11", 32'(alarm_busy), 32'(m_cnt > 0));
    sec_tick = 1'b0;
    alarm_wr = 1'b0;
    clr_wr = 1'b0;
  endtask

  task automatic write_alarm(input logic [29:0] w);
    alarm_wdata = w;
    alarm_wr = 1'b1;
    step();
    for (int i = 0; i < LAT; i++) step();
  endtask

  task automatic clear(input logic [1:0] m);
    clr_wr = 1'b1;
    clr_mask = m;
    step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1", 32'(status), 32'd0);
    chk("R1", 32'(irq), 32'd0);
    chk("R1", 32'(alarm_busy), 32'd0);

    // R11 + R4: matching tick during load uses old (all-disabled) alarm
    set_time(56, 34, 12, 15);
    alarm_wdata = mk_alarm(4'hF, 56, 34, 12, 15);
    alarm_wr = 1'b1;
    step();
    chk("R11", 32'(alarm_busy), 32'd1);
    sec_tick = 1'b1;
    step();
    chk("R11", 32'(status[0]), 32'd0);
    step(); step();
    chk("R11", 32'(alarm_busy), 32'd0);

    // R5: match without tick
    step();
    chk("R5", 32'(status[0]), 32'd0);
    // R2: tick with full match
    sec_tick = 1'b1;
    step();
    chk("R2", 32'(status[0]), 32'd1);
    chk("R10", 32'(irq), 32'd1);

    // R8: clear alarm bit only; update bit stays
    chk("R8", 32'(status[1]), 32'd0);
    upd_per_sec = 1'b1;
    sec_tick = 1'b1;
    set_time(3, 0, 0, 1);
    step();
    clear(2'b01);
    chk("R8", 32'(status), 32'b10);
    // R10: update bit gated by enable
    chk("R10", 32'(irq), 32'd0);
    upd_int_en = 1'b1;
    step();
    chk("R10", 32'(irq), 32'd1);
    upd_int_en = 1'b0;
    clear(2'b10);
    chk("R8", 32'(status), 32'd0);

    // R3: only seconds enabled, other fields differ
    write_alarm(mk_alarm(4'b0001, 30, 11, 9, 20));
    set_time(30, 45, 3, 2);
    sec_tick = 1'b1;
    step();
    chk("R3", 32'(status[0]), 32'd1);
    clear(2'b11);

    // R4: no enables, fields equal the time
    write_alarm(mk_alarm(4'b0000, 30, 45, 3, 2));
    sec_tick = 1'b1;
    step();
    chk("R4", 32'(status[0]), 32'd0);

    // R9: set and clear in the same cycle
    write_alarm(mk_alarm(4'b1100, 0, 0, 3, 2));
    sec_tick = 1'b1;
    clr_wr = 1'b1;
    clr_mask = 2'b11;
    step();
    chk("R9", 32'(status[0]), 32'd1);
    chk("R9", 32'(status[1]), 32'd1);
    clear(2'b11);

    // R7: per-minute mode
    upd_per_sec = 1'b0;
    set_time(45, 1, 1, 1);
    sec_tick = 1'b1;
    step();
    chk("R7", 32'(status[1]), 32'd0);
    set_time(0, 2, 1, 1);
    sec_tick = 1'b1;
    step();
    chk("R7", 32'(status[1]), 32'd1);
    clear(2'b11);
    // R6: per-second mode
    upd_per_sec = 1'b1;
    set_time(17, 2, 1, 1);
    sec_tick = 1'b1;
    step();
    chk("R6", 32'(status[1]), 32'd1);

    // Random sweep over a small value set so matches are frequent
    for (int it = 0; it < 3000; it++) begin
      int s, m, h, d;
      s = ($urandom % 4 == 3) ? 59 : int'($urandom % 3);
      m = int'($urandom % 2);
      h = int'($urandom % 2);
      d = 1 + int'($urandom % 2);
      set_time(s, m, h, d);
      sec_tick = ($urandom % 2) == 0;
      if ($urandom % 16 == 0) begin
        alarm_wdata = mk_alarm(4'($urandom), int'($urandom % 3),
                               int'($urandom % 2), int'($urandom % 2),
                               1 + int'($urandom % 2));
        alarm_wr = 1'b1;
      end
      if ($urandom % 4 == 0) begin
        clr_wr = 1'b1;
        clr_mask = 2'($urandom);
      end
      if ($urandom % 32 == 0) upd_per_sec = ~upd_per_sec;
      if ($urandom % 32 == 0) upd_int_en = ~upd_int_en;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule